// File: doc/BRIEF.md
# Received Stream Data Verifier

This block watches the payload stream of one receive session. Each cycle may carry a 32-bit word with a valid strobe, an end-of-packet marker, a per-lane byte enable and an 8-bit packet error code. The block does three things with that stream. It records packet errors and holds them until they are cleared. It keeps a running total of received bytes. It checks every word against an incrementing 32-bit pattern that starts from a seed, and it records where the first bad word was found.

A test controller loads the seed and pulses the start input to arm a run. It then lets traffic flow and reads the outputs. These are the sticky error flag and its code, the byte total, the fail flag, and the first-failure record: the position, the expected word and the word that was received. A separate clear pulse drops the error indication without disturbing the verification state. All outputs are registered and change on the clock edge after the input that causes the change.

Top module: `rx_stream_checker`

## Requirements
- R1: After reset is released, every output is zero and the expected pattern is zero.
- R2: The error code is sampled only in a cycle where valid and end-of-packet are both high. A non-zero sampled code sets the error flag and loads that code into the latched code one cycle later. A non-zero code in any other cycle has no effect.
- R3: A sampled code of zero leaves the error flag and the latched code unchanged. A later non-zero sample overwrites the latched code.
- R4: A clear pulse resets the error flag and the latched code to zero. If a non-zero code is sampled in the same cycle, the new error wins and is latched.
- R5: Byte-enable bit i marks bits 8i+7..8i of the data word as valid. Enables are contiguous from lane 0 (0001, 0011, 0111, 1111). Each valid cycle adds the number of set enable bits to a 48-bit byte count.
- R6: A start pulse loads the seed into the expected pattern. It clears the byte count, the fail flag and the three failure registers. A valid word in the start cycle is discarded. Start does not touch the error flag or the latched code.
- R7: The expected pattern advances by one, modulo 2^32, after every valid word, whether or not that word matched.
- R8: A valid word is a mismatch when verify enable is high and any enabled lane differs from the same lane of the expected pattern. Disabled lanes are ignored. When verify enable is low, no word sets the fail flag.
- R9: The fail flag is set one cycle after a mismatch and stays set until the next start pulse.
- R10: While the fail flag is low, each valid word loads three failure registers: the position, which is the byte count before that word, the expected pattern, and the raw received word. Once the fail flag is set, these registers hold the record of the first failing word and stay frozen until start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a run: loads the seed and clears the count and failure state |
| verify_en_i | input | 1 | Enables the pattern comparison |
| clear_i | input | 1 | Clears the error flag and the latched code |
| seed_i | input | 32 | Start value of the pattern |
| rx_valid_i | input | 1 | Word valid |
| rx_eop_i | input | 1 | Last word of the packet |
| rx_be_i | input | 4 | Per-lane byte enables |
| rx_data_i | input | 32 | Received word |
| rx_err_i | input | 8 | Packet error code, meaningful only at end of packet |
| err_flag_o | output | 1 | Sticky packet error indication |
| err_code_o | output | 8 | Last non-zero error code sampled |
| byte_cnt_o | output | 48 | Bytes received since start |
| fail_o | output | 1 | Pattern mismatch seen since start |
| fail_pos_o | output | 48 | Byte position of the first failing word |
| fail_exp_o | output | 32 | Expected word at the first failure |
| fail_act_o | output | 32 | Received word at the first failure |

## Verification
Two pairs of events can land in the same cycle. The first pair is a clear pulse and an end-of-packet word carrying a non-zero code. The second pair is a start pulse and a valid word. The bench drives both pairs on purpose. During a sweep over all 256 error codes, a clear pulse goes out with every fourth end-of-packet word. A valid mismatching word is also driven together with a start pulse. The judgement is that the new error survives its clear, and that the word under start changes neither the count, nor the pattern, nor the fail flag.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned RSC_DATA_W = 32;
  localparam int unsigned RSC_CNT_W  = 48;
  localparam int unsigned RSC_ERR_W  = 8;
  localparam int unsigned RSC_LANE_W = 8;
endpackage

// File: rtl/rsc_err_capture.sv
module rsc_err_capture #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [ERR_W-1:0] code_i,
  input  logic             clear_i,
  output logic             flag_o,
  output logic [ERR_W-1:0] code_o
);
  logic             flag_q;
  logic [ERR_W-1:0] code_q;
  logic             hit;

  assign hit = sample_i && (code_i != '0);

  // a fresh error outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else if (hit) begin
      flag_q <= 1'b1;
      code_q <= code_i;
    end else if (clear_i) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end
  end

  assign flag_o = flag_q;
  assign code_o = code_q;
endmodule

// File: rtl/rsc_byte_tally.sv
module rsc_byte_tally #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [LANES-1:0] be_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned NB_W = $clog2(LANES + 1);

  logic [NB_W-1:0]  nbytes;
  logic [CNT_W-1:0] count_q;

  always_comb begin
    nbytes = '0;
    for (int i = 0; i < LANES; i++) begin
      nbytes = nbytes + NB_W'(be_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (start_i) begin
      count_q <= '0;
    end else if (valid_i) begin
      count_q <= count_q + CNT_W'(nbytes);
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/rsc_pattern_gen.sv
module rsc_pattern_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] seed_i,
  input  logic              adv_i,
  output logic [DATA_W-1:0] exp_o
);
  logic [DATA_W-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
    end else if (start_i) begin
      exp_q <= seed_i;
    end else if (adv_i) begin
      exp_q <= exp_q + DATA_W'(1);
    end
  end

  assign exp_o = exp_q;
endmodule

// File: rtl/rsc_fail_capture.sv
module rsc_fail_capture #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              verify_en_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [CNT_W-1:0]  pos_i,
  output logic              fail_o,
  output logic [CNT_W-1:0]  pos_o,
  output logic [DATA_W-1:0] exp_o,
  output logic [DATA_W-1:0] act_o
);
  logic [DATA_W-1:0] lane_mask;
  logic              mismatch;
  logic              fail_q;
  logic [CNT_W-1:0]  pos_q;
  logic [DATA_W-1:0] exp_q;
  logic [DATA_W-1:0] act_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{be_i[g]}};
  end

  assign mismatch = valid_i && verify_en_i && (((data_i ^ exp_i) & lane_mask) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      pos_q  <= '0;
      exp_q  <= '0;
      act_q  <= '0;
    end else if (start_i) begin
      fail_q <= 1'b0;
      pos_q  <= '0;
      exp_q  <= '0;
      act_q  <= '0;
    end else if (valid_i) begin
      // record tracks every word until the first failure, then freezes
      if (!fail_q) begin
        pos_q <= pos_i;
        exp_q <= exp_i;
        act_q <= data_i;
      end
      if (mismatch) fail_q <= 1'b1;
    end
  end

  assign fail_o = fail_q;
  assign pos_o  = pos_q;
  assign exp_o  = exp_q;
  assign act_o  = act_q;
endmodule

// File: rtl/rx_stream_checker.sv
module rx_stream_checker
  import rsc_pkg::*;
#(
  parameter int unsigned DATA_W = RSC_DATA_W,
  parameter int unsigned CNT_W  = RSC_CNT_W,
  parameter int unsigned ERR_W  = RSC_ERR_W,
  localparam int unsigned LANES = DATA_W / RSC_LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              verify_en_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] seed_i,
  input  logic              rx_valid_i,
  input  logic              rx_eop_i,
  input  logic [LANES-1:0]  rx_be_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  output logic              err_flag_o,
  output logic [ERR_W-1:0]  err_code_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  fail_pos_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_act_o
);
  logic              accept;
  logic [DATA_W-1:0] exp_word;
  logic [CNT_W-1:0]  count;

  assign accept = rx_valid_i && !start_i;

  rsc_err_capture #(.ERR_W(ERR_W)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (rx_valid_i && rx_eop_i),
    .code_i   (rx_err_i),
    .clear_i  (clear_i),
    .flag_o   (err_flag_o),
    .code_o   (err_code_o)
  );

  rsc_byte_tally #(.LANES(LANES), .CNT_W(CNT_W)) u_tally (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (rx_valid_i),
    .be_i    (rx_be_i),
    .count_o (count)
  );

  rsc_pattern_gen #(.DATA_W(DATA_W)) u_pat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .seed_i  (seed_i),
    .adv_i   (accept),
    .exp_o   (exp_word)
  );

  rsc_fail_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LANE_W(RSC_LANE_W)) u_fail (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .valid_i     (rx_valid_i),
    .verify_en_i (verify_en_i),
    .be_i        (rx_be_i),
    .data_i      (rx_data_i),
    .exp_i       (exp_word),
    .pos_i       (count),
    .fail_o      (fail_o),
    .pos_o       (fail_pos_o),
    .exp_o       (fail_exp_o),
    .act_o       (fail_act_o)
  );

  assign byte_cnt_o = count;
endmodule

// File: rtl/rx_stream_checker_sva.sv
module rx_stream_checker_sva #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned ERR_W  = 8,
  parameter int unsigned LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              verify_en_i,
  input logic              clear_i,
  input logic              rx_valid_i,
  input logic              rx_eop_i,
  input logic [LANES-1:0]  rx_be_i,
  input logic [ERR_W-1:0]  rx_err_i,
  input logic              err_flag_o,
  input logic [ERR_W-1:0]  err_code_o,
  input logic [CNT_W-1:0]  byte_cnt_o,
  input logic              fail_o,
  input logic [CNT_W-1:0]  fail_pos_o,
  input logic [DATA_W-1:0] fail_exp_o,
  input logic [DATA_W-1:0] fail_act_o
);
  // R2
  err_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_eop_i && rx_err_i != '0) |=> (err_flag_o && err_code_o == $past(rx_err_i)));

  // R3
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rx_valid_i && rx_eop_i) && !clear_i) |=> ($stable(err_flag_o) && $stable(err_code_o)));

  // R4
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !(rx_valid_i && rx_eop_i && rx_err_i != '0)) |=> (!err_flag_o && err_code_o == '0));

  // R5
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !rx_valid_i) |=> $stable(byte_cnt_o));

  // R6
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (byte_cnt_o == '0 && !fail_o && fail_pos_o == '0));

  // R8
  no_verify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!verify_en_i && !fail_o && !start_i) |=> !fail_o);

  // R9
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o);

  // R10
  rec_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> ($stable(fail_pos_o) && $stable(fail_exp_o) && $stable(fail_act_o)));
endmodule

bind rx_stream_checker rx_stream_checker_sva #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .ERR_W(ERR_W), .LANES(LANES)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .verify_en_i (verify_en_i),
  .clear_i     (clear_i),
  .rx_valid_i  (rx_valid_i),
  .rx_eop_i    (rx_eop_i),
  .rx_be_i     (rx_be_i),
  .rx_err_i    (rx_err_i),
  .err_flag_o  (err_flag_o),
  .err_code_o  (err_code_o),
  .byte_cnt_o  (byte_cnt_o),
  .fail_o      (fail_o),
  .fail_pos_o  (fail_pos_o),
  .fail_exp_o  (fail_exp_o),
  .fail_act_o  (fail_act_o)
);

// File: tb/sim_rx_stream_checker.sv
module sim_rx_stream_checker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, verify_en_i = 1'b0, clear_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic        rx_valid_i = 1'b0, rx_eop_i = 1'b0;
  logic [3:0]  rx_be_i = '0;
  logic [31:0] rx_data_i = '0;
  logic [7:0]  rx_err_i = '0;
  logic        err_flag_o, fail_o;
  logic [7:0]  err_code_o;
  logic [47:0] byte_cnt_o, fail_pos_o;
  logic [31:0] fail_exp_o, fail_act_o;

  int checks = 0;
  int errors = 0;

  // bench model
  logic        m_flag = 0, m_fail = 0;
  logic [7:0]  m_code = 0;
  logic [47:0] m_cnt = 0, m_pos = 0;
  logic [31:0] m_exp = 0, m_fexp = 0, m_fact = 0;

  always #2 clk_i = ~clk_i;

  rx_stream_checker u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .verify_en_i(verify_en_i),
    .clear_i(clear_i), .seed_i(seed_i), .rx_valid_i(rx_valid_i), .rx_eop_i(rx_eop_i),
    .rx_be_i(rx_be_i), .rx_data_i(rx_data_i), .rx_err_i(rx_err_i),
    .err_flag_o(err_flag_o), .err_code_o(err_code_o), .byte_cnt_o(byte_cnt_o),
    .fail_o(fail_o), .fail_pos_o(fail_pos_o), .fail_exp_o(fail_exp_o), .fail_act_o(fail_act_o)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "err_flag", 64'(err_flag_o), 64'(m_flag));
    chk(tag, "err_code", 64'(err_code_o), 64'(m_code));
    chk(tag, "byte_cnt", 64'(byte_cnt_o), 64'(m_cnt));
    chk(tag, "fail", 64'(fail_o), 64'(m_fail));
    chk(tag, "fail_pos", 64'(fail_pos_o), 64'(m_pos));
    chk(tag, "fail_exp", 64'(fail_exp_o), 64'(m_fexp));
    chk(tag, "fail_act", 64'(fail_act_o), 64'(m_fact));
  endtask

  // drive one cycle at negedge, model the edge, sample at next negedge
  task automatic step(input string tag, input logic v, input logic eop, input logic [3:0] be,
                      input logic [31:0] d, input logic [7:0] e, input logic st,
                      input logic cl, input logic ven);
    logic [31:0] mask;
    logic [2:0]  nb;
    logic        mism;
    rx_valid_i = v; rx_eop_i = eop; rx_be_i = be; rx_data_i = d; rx_err_i = e;
    start_i = st; clear_i = cl; verify_en_i = ven;
    mask = '0; nb = '0;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) begin
        mask[8*i +: 8] = 8'hFF;
        nb = nb + 3'd1;
      end
    end
    @(posedge clk_i);
    if (v && eop && e != 0) begin
      m_flag = 1; m_code = e;
    end else if (cl) begin
      m_flag = 0; m_code = 0;
    end
    if (st) begin
      m_cnt = 0; m_exp = seed_i; m_fail = 0; m_pos = 0; m_fexp = 0; m_fact = 0;
    end else if (v) begin
      mism = ven && (((d ^ m_exp) & mask) != 0);
      if (!m_fail) begin
        m_pos = m_cnt; m_fexp = m_exp; m_fact = d;
      end
      if (mism) m_fail = 1;
      m_cnt = m_cnt + 48'(nb);
      m_exp = m_exp + 1;
    end
    @(negedge clk_i);
    rx_valid_i = 0; rx_eop_i = 0; start_i = 0; clear_i = 0; rx_err_i = 0;
    compare_all(tag);
  endtask

  task automatic arm(input logic [31:0] s);
    seed_i = s;
    step("R6", 0, 0, 4'h0, 0, 0, 1, 0, 1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] bes [4];
    bes[0] = 4'h1; bes[1] = 4'h3; bes[2] = 4'h7; bes[3] = 4'hF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R1");

    // R7 R5: full words matching, including a wrap of the pattern
    arm(32'hFFFF_FFFD);
    for (int k = 0; k < 6; k++) step("R7", 1, 0, 4'hF, m_exp, 0, 0, 0, 1);

    // R5 R8: every contiguous enable, junk only in disabled lanes
    arm(32'h1234_5600);
    for (int k = 0; k < 16; k++) begin
      logic [3:0]  be = bes[k % 4];
      logic [31:0] junk = 32'hA5C3_0F96 ^ (32'(k) * 32'h0101_0101);
      logic [31:0] d = m_exp;
      for (int i = 0; i < 4; i++) if (!be[i]) d[8*i +: 8] = junk[8*i +: 8];
      step("R5", 1, 0, be, d, 0, 0, 0, 1);
    end

    // R8: mismatches with verify off never fail
    for (int k = 0; k < 8; k++) step("R8", 1, 0, 4'hF, ~m_exp, 0, 0, 0, 0);

    // R8 R9 R10: mismatch in each enabled lane, for each enable width
    for (int b = 0; b < 4; b++) begin
      for (int lane = 0; lane <= b; lane++) begin
        arm(32'h0000_0100 * 32'(b + 1));
        step("R10", 1, 0, bes[b], m_exp, 0, 0, 0, 1);
        step("R10", 1, 0, bes[b], m_exp ^ (32'h0000_0001 << (8 * lane)), 0, 0, 0, 1);
        chk("R9", "fail set", 64'(fail_o), 64'd1);
        step("R10", 1, 0, 4'hF, ~m_exp, 0, 0, 0, 1);
        step("R9", 1, 0, 4'hF, m_exp, 0, 0, 0, 1);
        step("R9", 0, 0, 4'h0, 0, 0, 0, 0, 1);
      end
    end

    // R6: start together with a mismatching valid word
    seed_i = 32'h0BAD_F00D;
    step("R6", 1, 1, 4'hF, 32'hDEAD_BEEF, 8'h00, 1, 0, 1);
    chk("R6", "pattern from seed", 64'(fail_o), 64'd0);
    step("R6", 1, 0, 4'hF, 32'h0BAD_F00D, 0, 0, 0, 1);

    // R2 R3 R4: sweep all codes, clear coincides with every fourth sample
    for (int c = 0; c < 256; c++) begin
      step("R2", 1, 1, 4'hF, m_exp, 8'(c), 0, (c % 4 == 3), 1);
      if (c % 16 == 5) step("R4", 0, 0, 4'h0, 0, 0, 0, 1, 1);
    end
    // R2: non-zero code without eop, or eop without valid, is ignored
    step("R4", 0, 0, 4'h0, 0, 0, 0, 1, 1);
    step("R2", 1, 0, 4'hF, m_exp, 8'h5A, 0, 0, 1);
    step("R2", 0, 1, 4'hF, m_exp, 8'h5A, 0, 0, 1);
    chk("R2", "flag stays low", 64'(err_flag_o), 64'd0);
    step("R3", 1, 1, 4'hF, m_exp, 8'h33, 0, 0, 1);
    step("R3", 1, 1, 4'hF, m_exp, 8'h00, 0, 0, 1);
    step("R3", 1, 1, 4'hF, m_exp, 8'h44, 0, 0, 1);
    // R6: start leaves the error state alone
    arm(32'h0);
    chk("R6", "err kept", 64'(err_code_o), 64'h44);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule